// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which operating mode the chip is in and drives the clock gates and the regulator choice that go with it. It knows six modes: a full-speed run mode, a light sleep (wait) and a deep sleep (stop) below it, and a reduced-frequency run mode with its own light and deep sleeps. The core requests sleep with a single-cycle strobe, and a deep qualifier picks the stop-type mode over the wait-type mode. Software moves between the two run modes by writing a 2-bit run-mode field. A wake-up interrupt brings the chip back to the run mode that the sleep was entered from.

Deep sleep is entered in two steps. The core clock is switched off at once. The system and bus clocks stay on until every peripheral has acknowledged the stop request. The acknowledges are resynchronised before they are combined. A wake-up that arrives during this handshake cancels the entry, and the system clock is never gated. On leaving deep sleep the system and bus clocks return one cycle before the core clock. All outputs are registered and follow the mode state register on the same clock edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: After a synchronous reset the block is in full-speed run: core, system and bus clocks enabled, run regulation (`reg_stop_sel`=0), `freq_limit`=0, `mode_stat`=0.
- R2: A sleep strobe without the deep qualifier in full-speed run enters wait (`mode_stat`=1) on the next edge. The core clock is off, the system and bus clocks stay on, and run regulation is kept.
- R3: A sleep strobe with the deep qualifier in full-speed run gates the core clock on the next edge (`mode_stat`=2). The system and bus clocks stay on until every `stop_ack` bit has been high for ACK_SYNC+1 edges, and are then gated. Run regulation is kept throughout.
- R4: Writing run-mode code 2'b10 in full-speed run enters reduced-frequency run (`mode_stat`=3, `freq_limit`=1, `reg_stop_sel`=1, all clocks on). Writing code 2'b00 in reduced-frequency run returns to full-speed run.
- R5: A run-mode write has no effect on the mode or the outputs in any of these cases: code 2'b10 outside full-speed run, code 2'b00 outside reduced-frequency run, and codes 2'b01 or 2'b11 in any mode.
- R6: From reduced-frequency run, a plain sleep strobe enters low-power wait (`mode_stat`=4). A deep sleep strobe enters low-power stop (`mode_stat`=5), which uses the same acknowledge handshake as R3. Every reduced-frequency mode keeps `freq_limit`=1 and `reg_stop_sel`=1.
- R7: A wake-up in wait returns to full-speed run on the next edge. A wake-up in low-power wait returns to reduced-frequency run on the next edge.
- R8: A wake-up in stop or low-power stop turns the system and bus clocks on at the next edge while the core clock stays off. The core clock turns on one edge later, in full-speed run or reduced-frequency run respectively.
- R9: A wake-up while the acknowledge handshake is pending returns on the next edge to the run mode the sleep was requested from, and the system clock is never gated.
- R10: A wake-up in either run mode, and a sleep strobe in any mode other than the two run modes, leave the mode and the outputs unchanged.
- R11: A sleep strobe and a run-mode write in the same cycle: the sleep strobe wins and the write is dropped.
- R12: Whenever the core clock is enabled, the system and bus clocks are enabled too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Single-cycle sleep request from the core |
| sleep_deep | input | 1 | Qualifier: 1 selects a stop-type mode, 0 a wait-type mode |
| rm_wr | input | 1 | Run-mode field write strobe |
| rm_wdata | input | 2 | Run-mode code written (2'b00 full speed, 2'b10 reduced frequency) |
| stop_ack | input | N_PERIPH | Per-peripheral stop acknowledge, asynchronous |
| wake_irq | input | 1 | Wake-up interrupt |
| core_clk_on | output | 1 | Core clock enable |
| sys_clk_on | output | 1 | System clock enable |
| bus_clk_on | output | 1 | Bus clock enable |
| reg_stop_sel | output | 1 | 1 selects stop regulation, 0 run regulation |
| freq_limit | output | 1 | Reduced-frequency limit in force |
| mode_stat | output | 3 | Current mode: 0 run, 1 wait, 2 stop, 3 low-power run, 4 low-power wait, 5 low-power stop |

## Verification
Sleep is tried with the deep qualifier low and high from each run mode. These patterns tell apart the four sleep targets and the regulator and limit flags that belong to each. The acknowledges are held low and then raised together during a stop entry, and the bench samples at the edge just before and the edge just after the expected gating. This exposes a handshake that is skipped or one with the wrong latency. Wake-ups are applied in each sleep state, during the pending handshake, and in the run modes. Run-mode writes are tried with every code in every reachable mode, which separates accepted writes from ignored ones. A combined sleep and write strobe shows which of the two takes priority.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [3:0] {
    ST_RUN       = 4'd0,
    ST_WAIT      = 4'd1,
    ST_STOP_HS   = 4'd2,
    ST_STOP      = 4'd3,
    ST_STOP_RES  = 4'd4,
    ST_VRUN      = 4'd5,
    ST_VWAIT     = 4'd6,
    ST_VSTOP_HS  = 4'd7,
    ST_VSTOP     = 4'd8,
    ST_VSTOP_RES = 4'd9
  } pm_state_e;

  localparam logic [1:0] RMODE_NORMAL = 2'b00;
  localparam logic [1:0] RMODE_LOWPWR = 2'b10;

  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] STAT_RUN   = 3'd0;
  localparam logic [STAT_W-1:0] STAT_WAIT  = 3'd1;
  localparam logic [STAT_W-1:0] STAT_STOP  = 3'd2;
  localparam logic [STAT_W-1:0] STAT_VRUN  = 3'd3;
  localparam logic [STAT_W-1:0] STAT_VWAIT = 3'd4;
  localparam logic [STAT_W-1:0] STAT_VSTOP = 3'd5;

  typedef struct packed {
    logic              core_on;
    logic              sys_on;
    logic              bus_on;
    logic              reg_stop;
    logic              freq_lim;
    logic [STAT_W-1:0] stat;
  } pm_out_t;

  function automatic pm_out_t pm_decode(pm_state_e s);
    pm_out_t o;
    o = '{core_on: 1'b1, sys_on: 1'b1, bus_on: 1'b1, reg_stop: 1'b0,
          freq_lim: 1'b0, stat: STAT_RUN};
    unique case (s)
      ST_RUN:       o.stat = STAT_RUN;
      ST_WAIT:      begin o.core_on = 1'b0; o.stat = STAT_WAIT; end
      ST_STOP_HS:   begin o.core_on = 1'b0; o.stat = STAT_STOP; end
      ST_STOP:      begin o.core_on = 1'b0; o.sys_on = 1'b0; o.bus_on = 1'b0;
                          o.stat = STAT_STOP; end
      ST_STOP_RES:  begin o.core_on = 1'b0; o.stat = STAT_STOP; end
      ST_VRUN:      begin o.reg_stop = 1'b1; o.freq_lim = 1'b1; o.stat = STAT_VRUN; end
      ST_VWAIT:     begin o.core_on = 1'b0; o.reg_stop = 1'b1; o.freq_lim = 1'b1;
                          o.stat = STAT_VWAIT; end
      ST_VSTOP_HS:  begin o.core_on = 1'b0; o.reg_stop = 1'b1; o.freq_lim = 1'b1;
                          o.stat = STAT_VSTOP; end
      ST_VSTOP:     begin o.core_on = 1'b0; o.sys_on = 1'b0; o.bus_on = 1'b0;
                          o.reg_stop = 1'b1; o.freq_lim = 1'b1; o.stat = STAT_VSTOP; end
      ST_VSTOP_RES: begin o.core_on = 1'b0; o.reg_stop = 1'b1; o.freq_lim = 1'b1;
                          o.stat = STAT_VSTOP; end
      default:      o.stat = STAT_RUN;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pwr_ack_sync.sv
module pwr_ack_sync #(
  parameter int N_PERIPH = 4,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] ack_in,
  output logic                all_ack
);

  generate
    if (STAGES == 0) begin : g_direct
      assign all_ack = &ack_in;
    end else begin : g_sync
      logic [N_PERIPH-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= ack_in;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
      assign all_ack = &stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_req,
  input  logic       sleep_deep,
  input  logic       rm_wr,
  input  logic [1:0] rm_wdata,
  input  logic       all_ack,
  input  logic       wake,
  output pm_state_e  state_d
);

  pm_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req)
          state_d = sleep_deep ? ST_STOP_HS : ST_WAIT;
        else if (rm_wr && rm_wdata == RMODE_LOWPWR)
          state_d = ST_VRUN;
      end
      ST_WAIT:      if (wake) state_d = ST_RUN;
      ST_STOP_HS: begin
        if (wake)         state_d = ST_RUN;
        else if (all_ack) state_d = ST_STOP;
      end
      ST_STOP:      if (wake) state_d = ST_STOP_RES;
      ST_STOP_RES:  state_d = ST_RUN;
      ST_VRUN: begin
        if (sleep_req)
          state_d = sleep_deep ? ST_VSTOP_HS : ST_VWAIT;
        else if (rm_wr && rm_wdata == RMODE_NORMAL)
          state_d = ST_RUN;
      end
      ST_VWAIT:     if (wake) state_d = ST_VRUN;
      ST_VSTOP_HS: begin
        if (wake)         state_d = ST_VRUN;
        else if (all_ack) state_d = ST_VSTOP;
      end
      ST_VSTOP:     if (wake) state_d = ST_VSTOP_RES;
      ST_VSTOP_RES: state_d = ST_VRUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pm_state_e state_d,
  output pm_out_t   out_q
);

  always_ff @(posedge clk) begin
    if (rst) out_q <= pm_decode(ST_RUN);
    else     out_q <= pm_decode(state_d);
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_PERIPH = 4,
  parameter int ACK_SYNC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_req,
  input  logic                sleep_deep,
  input  logic                rm_wr,
  input  logic [1:0]          rm_wdata,
  input  logic [N_PERIPH-1:0] stop_ack,
  input  logic                wake_irq,
  output logic                core_clk_on,
  output logic                sys_clk_on,
  output logic                bus_clk_on,
  output logic                reg_stop_sel,
  output logic                freq_limit,
  output logic [STAT_W-1:0]   mode_stat
);

  logic      all_ack;
  pm_state_e state_d;
  pm_out_t   out_q;

  pwr_ack_sync #(.N_PERIPH(N_PERIPH), .STAGES(ACK_SYNC)) u_ack (
    .clk(clk), .rst(rst), .ack_in(stop_ack), .all_ack(all_ack)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
    .rm_wr(rm_wr), .rm_wdata(rm_wdata), .all_ack(all_ack), .wake(wake_irq),
    .state_d(state_d)
  );

  pwr_out_reg u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .out_q(out_q)
  );

  assign core_clk_on  = out_q.core_on;
  assign sys_clk_on   = out_q.sys_on;
  assign bus_clk_on   = out_q.bus_on;
  assign reg_stop_sel = out_q.reg_stop;
  assign freq_limit   = out_q.freq_lim;
  assign mode_stat    = out_q.stat;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int N_PERIPH = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [N_PERIPH-1:0] stop_ack,
  input logic                core_clk_on,
  input logic                sys_clk_on,
  input logic                bus_clk_on,
  input logic                reg_stop_sel,
  input logic                freq_limit,
  input logic [2:0]          mode_stat
);

  // R12
  core_needs_sys_chk: assert property (@(posedge clk) disable iff (rst)
    core_clk_on |-> (sys_clk_on && bus_clk_on));

  // R3
  core_gated_first_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk_on) |-> (!core_clk_on && $past(!core_clk_on)));

  // R8
  sys_back_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_on) |-> $past(sys_clk_on));

  // R6
  lowpwr_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_stat >= 3'd3) |-> (reg_stop_sel && freq_limit));

  // R1
  stat_range_chk: assert property (@(posedge clk) disable iff (rst)
    mode_stat <= 3'd5);

  // R6
  vwait_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 3'd4 && $past(mode_stat) != 3'd4) |-> $past(mode_stat) == 3'd3);

  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 3'd2 && $past(mode_stat) != 3'd2) |-> $past(mode_stat) == 3'd0);

  // R3
  sys_off_acked_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_clk_on) |-> $past(&stop_ack));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_PERIPH(N_PERIPH)) u_chk (
  .clk(clk), .rst(rst), .stop_ack(stop_ack), .core_clk_on(core_clk_on),
  .sys_clk_on(sys_clk_on), .bus_clk_on(bus_clk_on), .reg_stop_sel(reg_stop_sel),
  .freq_limit(freq_limit), .mode_stat(mode_stat)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
  localparam int N = 4;
  localparam int SY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, sleep_deep = 1'b0, rm_wr = 1'b0, wake_irq = 1'b0;
  logic [1:0] rm_wdata = 2'b00;
  logic [N-1:0] stop_ack = '0;
  logic core_clk_on, sys_clk_on, bus_clk_on, reg_stop_sel, freq_limit;
  logic [2:0] mode_stat;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int sys_low_cnt = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.N_PERIPH(N), .ACK_SYNC(SY)) u_pwr_mode_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_deep(sleep_deep),
    .rm_wr(rm_wr), .rm_wdata(rm_wdata), .stop_ack(stop_ack), .wake_irq(wake_irq),
    .core_clk_on(core_clk_on), .sys_clk_on(sys_clk_on), .bus_clk_on(bus_clk_on),
    .reg_stop_sel(reg_stop_sel), .freq_limit(freq_limit), .mode_stat(mode_stat)
  );

  always @(negedge clk) if (!rst && !sys_clk_on) sys_low_cnt++;

  // expected vector: {stat, core, sys, bus, reg_stop, freq_limit}
  task automatic chk(string req, logic [2:0] st, logic c, logic s, logic b,
                     logic rg, logic fl);
    logic [7:0] act, exp;
    act = {mode_stat, core_clk_on, sys_clk_on, bus_clk_on, reg_stop_sel, freq_limit};
    exp = {st, c, s, b, rg, fl};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sleep(logic deep);
    @(negedge clk); sleep_req = 1'b1; sleep_deep = deep;
    @(negedge clk); sleep_req = 1'b0; sleep_deep = 1'b0;
  endtask

  task automatic wr(logic [1:0] d);
    @(negedge clk); rm_wr = 1'b1; rm_wdata = d;
    @(negedge clk); rm_wr = 1'b0;
  endtask

  task automatic wake();
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; stop_ack = '0; tick(SY + 3); rst = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset", 3'd0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_wait();
    sleep(1'b0);
    chk("R2 wait entry", 3'd1, 0, 1, 1, 0, 0);
    wake();
    chk("R7 wait wake", 3'd0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_stop();
    int low0;
    sleep(1'b1);
    chk("R3 core gated", 3'd2, 0, 1, 1, 0, 0);
    tick(3);
    chk("R3 held without acks", 3'd2, 0, 1, 1, 0, 0);
    stop_ack = '1;
    tick(SY);
    chk("R3 before ack latency", 3'd2, 0, 1, 1, 0, 0);
    tick(1);
    chk("R3 stopped", 3'd2, 0, 0, 0, 0, 0);
    sleep(1'b0);
    chk("R10 sleep in stop", 3'd2, 0, 0, 0, 0, 0);
    low0 = sys_low_cnt;
    wake();
    chk("R8 sys back first", 3'd2, 0, 1, 1, 0, 0);
    tick(1);
    chk("R8 core back", 3'd0, 1, 1, 1, 0, 0);
    stop_ack = '0; tick(SY + 1);
  endtask

  task automatic t_vrun();
    wr(2'b10);
    chk("R4 enter low-power run", 3'd3, 1, 1, 1, 1, 1);
    wr(2'b10);
    chk("R5 repeat code ignored", 3'd3, 1, 1, 1, 1, 1);
    wr(2'b01);
    chk("R5 code 01 ignored", 3'd3, 1, 1, 1, 1, 1);
    wake();
    chk("R10 wake in low-power run", 3'd3, 1, 1, 1, 1, 1);
    wr(2'b00);
    chk("R4 back to run", 3'd0, 1, 1, 1, 0, 0);
    wr(2'b00);
    chk("R5 code 00 in run ignored", 3'd0, 1, 1, 1, 0, 0);
    wr(2'b11);
    chk("R5 code 11 ignored", 3'd0, 1, 1, 1, 0, 0);
    wake();
    chk("R10 wake in run", 3'd0, 1, 1, 1, 0, 0);
    sleep(1'b0);
    wr(2'b10);
    chk("R5 write in wait ignored", 3'd1, 0, 1, 1, 0, 0);
    wake();
    chk("R7 wake to run", 3'd0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_vlp_sleep();
    wr(2'b10);
    sleep(1'b0);
    chk("R6 low-power wait", 3'd4, 0, 1, 1, 1, 1);
    sleep(1'b1);
    chk("R10 sleep in low-power wait", 3'd4, 0, 1, 1, 1, 1);
    wake();
    chk("R7 low-power wait wake", 3'd3, 1, 1, 1, 1, 1);
    sleep(1'b1);
    chk("R6 low-power stop handshake", 3'd5, 0, 1, 1, 1, 1);
    stop_ack = '1;
    tick(SY + 1);
    chk("R6 low-power stopped", 3'd5, 0, 0, 0, 1, 1);
    wake();
    chk("R8 low-power sys back", 3'd5, 0, 1, 1, 1, 1);
    tick(1);
    chk("R8 low-power core back", 3'd3, 1, 1, 1, 1, 1);
    stop_ack = '0; tick(SY + 1);
  endtask

  task automatic t_abort();
    int low0;
    low0 = sys_low_cnt;
    sleep(1'b1);
    stop_ack = 4'b0111;
    tick(SY + 2);
    chk("R3 partial acks hold", 3'd5, 0, 1, 1, 1, 1);
    wake();
    chk("R9 abort to low-power run", 3'd3, 1, 1, 1, 1, 1);
    stop_ack = '0;
    wr(2'b00);
    sleep(1'b1);
    tick(2);
    wake();
    chk("R9 abort to run", 3'd0, 1, 1, 1, 0, 0);
    n_tests++;
    if (sys_low_cnt != low0) begin
      n_fail++;
      $display("FAIL R9 sys gated during abort actual=%0d expected=0", sys_low_cnt - low0);
    end
  endtask

  task automatic t_priority();
    @(negedge clk); sleep_req = 1'b1; sleep_deep = 1'b0; rm_wr = 1'b1; rm_wdata = 2'b10;
    @(negedge clk); sleep_req = 1'b0; rm_wr = 1'b0;
    chk("R11 sleep wins", 3'd1, 0, 1, 1, 0, 0);
    wake();
    chk("R11 write dropped", 3'd0, 1, 1, 1, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wait();
    t_stop();
    t_vrun();
    t_vlp_sleep();
    t_abort();
    t_priority();
    do_reset();
    chk("R1 second reset", 3'd0, 1, 1, 1, 0, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule